// File: doc/BRIEF.md
# Serial Divider Configuration Loader

This block receives the divider and loop settings of a frequency synthesizer over a three-wire serial link. The link has a serial clock, a serial data line and a load strobe. All three lines are sampled in the system clock domain. Each line passes through its own flop synchronizer. Edges are then found on the synchronized copies, so the serial clock may run at any rate well below the system clock.

Each rising serial clock edge shifts one data bit into a 22-bit shift register. A rising strobe copies the whole shift register into a holding register, which drives the outputs. While the strobe stays high, the holding register follows the shift register on every serial clock edge. A falling strobe freezes the holding register.

The holding register is split into four fields:
- a 9-bit input-divider value
- a 10-bit feedback-divider value
- a loop bandwidth select bit
- two test bits

After reset the outputs read input divider 1, feedback divider 32, normal bandwidth, and both test bits at 0.

Top module: `serial_div_cfg`

## Requirements
- R1: After reset, ref_div_o = 1, fb_div_o = 32, bw_normal_o = 1 and test_o = 0.
- R2: Each rising edge of ser_clk_i shifts the current ser_data_i into bit 0 of the 22-bit shift register, and every other bit moves up by one place. A word is therefore sent most significant bit first, and the first bit sent ends up in bit 21.
- R3: A rising edge of ser_load_i copies the full shift register into the outputs.
- R4: While ser_load_i is low, serial clock activity does not change any output.
- R5: While ser_load_i is high, each rising ser_clk_i edge updates the outputs with the newly shifted register contents.
- R6: After ser_load_i falls, the outputs keep their values through any further serial traffic until the next rising edge of ser_load_i.
- R7: The 22-bit word is decoded as follows:
  - bit 21 drives bw_normal_o (1 = normal bandwidth, 0 = narrow bandwidth)
  - bits 20:19 drive test_o
  - bits 18:10 drive ref_div_o
  - bits 9:0 drive fb_div_o
- R8: When a serial clock rise and a strobe rise reach the synchronized domain in the same system cycle, the shift is applied first and the shifted word is transferred.
- R9: The shift register resets to the default word, so a strobe pulse with no bits shifted since reset leaves the outputs at the R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_data_i | input | 1 | Serial data, asynchronous |
| ser_load_i | input | 1 | Load strobe, asynchronous |
| ref_div_o | output | 9 | Input-divider value |
| fb_div_o | output | 10 | Feedback-divider value |
| bw_normal_o | output | 1 | 1 = normal bandwidth, 0 = narrow bandwidth |
| test_o | output | 2 | Test bits |

## Verification
Each test pattern targets one way the block could go wrong:
- Random 22-bit words, shifted with the strobe low and then loaded, check the bit order and the field positions. A word with a single bit set would expose a swapped or offset field.
- Further shifting after the strobe falls must leave the outputs frozen. This catches a holding register that updates on the wrong strobe edge.
- Partial words clocked in with the strobe held high must update the outputs bit by bit. This separates the transparent mode from a plain load.
- A serial edge issued in the same instant as the strobe rise tests the ordering rule.
- A strobe pulse straight after reset checks that the shift register resets to the default word.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int REF_W  = 9;
  localparam int FB_W   = 10;
  localparam int TEST_W = 2;
  localparam int WORD_W = 1 + TEST_W + REF_W + FB_W;

  typedef struct packed {
    logic              bw_normal;
    logic [TEST_W-1:0] test;
    logic [REF_W-1:0]  ref_div;
    logic [FB_W-1:0]   fb_div;
  } cfg_word_t;

  function automatic cfg_word_t default_word();
    cfg_word_t w;
    w.bw_normal = 1'b1;
    w.test      = '0;
    w.ref_div   = REF_W'(1);
    w.fb_div    = FB_W'(32);
    return w;
  endfunction

  function automatic cfg_word_t shift_in(cfg_word_t cur, logic bit_in);
    logic [WORD_W-1:0] v;
    v = {cur[WORD_W-2:0], bit_in};
    return cfg_word_t'(v);
  endfunction
endpackage

// File: rtl/sdc_sync.sv
module sdc_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else if (g == 0) stage_q[g] <= d_i;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdc_edge.sv
module sdc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/sdc_shift.sv
module sdc_shift
  import sdc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step_i,
  input  logic      bit_i,
  output cfg_word_t shift_q_o,
  output cfg_word_t shift_next_o
);
  cfg_word_t shift_q;

  assign shift_next_o = step_i ? shift_in(shift_q, bit_i) : shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= default_word();
    else        shift_q <= shift_next_o;
  end

  assign shift_q_o = shift_q;
endmodule

// File: rtl/sdc_hold.sv
module sdc_hold
  import sdc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_lvl_i,
  input  logic      load_rise_i,
  input  logic      step_i,
  input  cfg_word_t shift_next_i,
  output cfg_word_t hold_o
);
  logic      take;
  cfg_word_t hold_q;

  assign take = load_rise_i | (load_lvl_i & step_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= default_word();
    else if (take) hold_q <= shift_next_i;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/serial_div_cfg.sv
module serial_div_cfg
  import sdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_data_i,
  input  logic              ser_load_i,
  output logic [REF_W-1:0]  ref_div_o,
  output logic [FB_W-1:0]   fb_div_o,
  output logic              bw_normal_o,
  output logic [TEST_W-1:0] test_o
);
  logic [2:0] pins_s;
  logic       sclk_lvl;
  logic       data_s;
  logic       load_lvl;
  logic       sclk_rise;
  logic       load_rise;
  cfg_word_t  shift_q;
  cfg_word_t  shift_next;
  cfg_word_t  cfg_q;

  sdc_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ser_load_i, ser_data_i, ser_clk_i}),
    .q_o   (pins_s)
  );

  assign sclk_lvl = pins_s[0];
  assign data_s   = pins_s[1];
  assign load_lvl = pins_s[2];

  sdc_edge u_sclk_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (sclk_lvl),
    .rise_o (sclk_rise)
  );

  sdc_edge u_load_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (load_lvl),
    .rise_o (load_rise)
  );

  sdc_shift u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_i       (sclk_rise),
    .bit_i        (data_s),
    .shift_q_o    (shift_q),
    .shift_next_o (shift_next)
  );

  sdc_hold u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_lvl_i   (load_lvl),
    .load_rise_i  (load_rise),
    .step_i       (sclk_rise),
    .shift_next_i (shift_next),
    .hold_o       (cfg_q)
  );

  assign ref_div_o   = cfg_q.ref_div;
  assign fb_div_o    = cfg_q.fb_div;
  assign bw_normal_o = cfg_q.bw_normal;
  assign test_o      = cfg_q.test;
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker
  import sdc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      sclk_rise,
  input logic      load_lvl,
  input logic      load_rise,
  input logic      data_s,
  input cfg_word_t shift_q,
  input cfg_word_t shift_next,
  input cfg_word_t cfg_q
);
  // R2: a serial edge shifts one bit in at the bottom
  a_r2_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> shift_q == {$past(shift_q[WORD_W-2:0]), $past(data_s)});

  // R2: no serial edge, no shift
  a_r2_shift_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(shift_q));

  // R3 / R8: strobe rise transfers the word, shift applied first
  a_r3_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    load_rise |=> cfg_q == $past(shift_next));

  // R5: transparent while the strobe is high
  a_r5_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    (load_lvl && sclk_rise) |=> cfg_q == $past(shift_next));

  // R4 / R6: strobe low means outputs hold
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !load_lvl |=> $stable(cfg_q));
endmodule

bind serial_div_cfg sdc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclk_rise  (sclk_rise),
  .load_lvl   (load_lvl),
  .load_rise  (load_rise),
  .data_s     (data_s),
  .shift_q    (shift_q),
  .shift_next (shift_next),
  .cfg_q      (cfg_q)
);

// File: tb/serial_div_cfg_tb.sv
module serial_div_cfg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       sdata = 1'b0;
  logic       sload = 1'b0;
  logic [8:0] ref_div;
  logic [9:0] fb_div;
  logic       bw;
  logic [1:0] tst;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [21:0] sh_m;
  logic [21:0] hold_m;

  always #2.5 clk = ~clk;

  serial_div_cfg u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_clk_i   (sclk),
    .ser_data_i  (sdata),
    .ser_load_i  (sload),
    .ref_div_o   (ref_div),
    .fb_div_o    (fb_div),
    .bw_normal_o (bw),
    .test_o      (tst)
  );

  function automatic logic [21:0] pack_word(logic b, logic [1:0] t, logic [8:0] r, logic [9:0] m);
    return (22'(b) << 21) | (22'(t) << 19) | (22'(r) << 10) | 22'(m);
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [21:0] exp);
    logic [21:0] act;
    act = pack_word(bw, tst, ref_div, fb_div);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual bw=%0d test=%0d ref=%0d fb=%0d expected bw=%0d test=%0d ref=%0d fb=%0d",
               req, act[21], act[20:19], act[18:10], act[9:0],
               exp[21], exp[20:19], exp[18:10], exp[9:0]);
    end
  endtask

  task automatic clk_bit(logic b);
    sdata = b;
    wait_cyc(4);
    sclk = 1'b1;
    sh_m = {sh_m[20:0], b};
    if (sload) hold_m = sh_m;
    wait_cyc(4);
    sclk = 1'b0;
    wait_cyc(4);
  endtask

  task automatic send_word(logic [21:0] w);
    for (int i = 21; i >= 0; i--) clk_bit(w[i]);
  endtask

  task automatic strobe_up();
    sload = 1'b1;
    hold_m = sh_m;
    wait_cyc(5);
  endtask

  task automatic strobe_down();
    sload = 1'b0;
    wait_cyc(5);
  endtask

  localparam logic [21:0] DEF = (22'd1 << 21) | (22'd1 << 10) | 22'd32;

  initial begin
    logic [21:0] w;
    void'($urandom(32'd7));
    sh_m = DEF;
    hold_m = DEF;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    check("R1 reset defaults", DEF);

    // R9: strobe with no data shifted keeps defaults
    strobe_up();
    check("R9 empty strobe", DEF);
    strobe_down();

    // R7: single-bit words expose field positions
    send_word(22'h200000); strobe_up(); strobe_down();
    check("R7 bit21 bw only", 22'h200000);
    send_word(22'd1 << 19); strobe_up(); strobe_down();
    check("R7 test low bit", 22'd1 << 19);
    send_word(22'd1 << 10); strobe_up(); strobe_down();
    check("R7 ref lsb", 22'd1 << 10);

    // R2/R3: random words, loaded by strobe rise
    for (int k = 0; k < 12; k++) begin
      w = 22'($urandom());
      send_word(w);
      check("R4 no change while strobe low", hold_m);
      strobe_up();
      check("R3 R2 load random word", w);
      strobe_down();
    end

    // R6: traffic after the fall keeps outputs
    w = hold_m;
    send_word(22'($urandom()));
    check("R6 frozen after fall", w);

    // R5: transparent mode, partial words with strobe high
    strobe_up();
    for (int k = 0; k < 5; k++) begin
      clk_bit(1'($urandom()));
      check("R5 transparent per bit", sh_m);
    end
    strobe_down();

    // R8: serial edge and strobe rise at the same instant
    sdata = 1'b1;
    wait_cyc(4);
    sclk = 1'b1;
    sload = 1'b1;
    sh_m = {sh_m[20:0], 1'b1};
    hold_m = sh_m;
    wait_cyc(5);
    check("R8 shift before transfer", sh_m);
    sclk = 1'b0;
    wait_cyc(4);
    strobe_down();
    send_word(22'h155555);
    check("R6 frozen after R8 case", hold_m);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(500_000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule